// File: doc/BRIEF.md
# Voltage Code Lookup Sequencer

The block runs once after reset, when a start strobe arrives. It takes a fused voltage-condition code, keeps its low nine bits, and picks a regulator voltage ID from an eight-entry table. It then drives a byte-oriented I2C master through that master's command and status handshake, and writes the chosen ID into one register of the regulator. The bit-level I2C engine is a separate block. This sequencer only issues commands (enable, START, STOP, byte write, wait release, flag clears, event enables) and reacts to the master's status levels.

A transfer can fail through lost arbitration or a missing acknowledge. Lost arbitration before the address byte is sent has its own recovery, which clocks out one dummy byte. Lost arbitration during a later byte and a missing acknowledge each have a recovery of their own. Every recovery closes the bus and restarts the whole transaction once. A second failure raises a sticky fault flag and the sequencer halts. A clean finish raises a done flag, which also holds.

After each command, and after each state change, the status inputs are ignored for `GAP_CYC` cycles. This gives the master time to update its status levels before the sequencer reads them again.

Top module: `volt_code_seq`

## Requirements
- R1: Only `fuse_code_i[8:0]` is used. That value is compared for equality with 0x000, 0x001, 0x002, 0x004, 0x008, 0x010, 0x020 and 0x040, which select entries 0 to 7. Entry n gives voltage ID 0x53 minus n, so the IDs run from 0x53 for entry 0 down to 0x4C for entry 7.
- R2: A masked code that matches none of the eight keys uses entry 0, voltage ID 0x53.
- R3: A clean transaction is one START command, then byte writes 0x60, 0x54 and the voltage ID, then one STOP command. The 0x60 byte is written only after `txe_i` has been seen high. Each later byte, and the STOP, is issued only after `wait_i` has been seen high, together with a `wait_rel_o` pulse.
- R4: After STOP the sequencer waits until `busy_i` is low. It then drops `mst_en_o` and `ien_o` to zero and raises `done_o`. `done_o` then holds until reset, and no further command is issued even if `start_i` pulses again.
- R5: If `arb_lost_i` is seen while the address byte is pending, the sequencer pulses `clr_arb_o` together with a dummy byte write of 0x53. It then waits for `wait_i`, issues STOP, waits until the bus is not busy, disables the master and restarts from START.
- R6: If `arb_lost_i` is seen while waiting on the register byte, the data byte or the STOP point, the sequencer pulses `clr_arb_o` with no byte. It then follows the same wait, STOP, not-busy and restart path as R5.
- R7: If `nack_i` is seen, the sequencer issues STOP together with a `clr_nack_o` pulse. At that point `ien_o` is 3'b100: bit 2 is the acknowledge event enable, bit 1 the wait enable and bit 0 the data-empty enable. It then waits until the bus is not busy, disables the master and restarts from START.
- R8: When `arb_lost_i` and `nack_i` are high together, the arbitration recovery is taken and `clr_nack_o` is not pulsed.
- R9: Only one restart is allowed. An error seen after one restart raises `fault_o`, drops `mst_en_o` and halts. `fault_o` holds until reset, and later `start_i` pulses issue nothing.
- R10: In reset every output is zero, and `done_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; used once after reset |
| fuse_code_i | input | RAW_W | Fused voltage-condition code; low CODE_W bits used |
| txe_i | input | 1 | Master: transmit data register empty |
| wait_i | input | 1 | Master: post-byte wait state |
| arb_lost_i | input | 1 | Master: arbitration lost flag |
| nack_i | input | 1 | Master: missing acknowledge flag |
| busy_i | input | 1 | Master: bus busy |
| mst_en_o | output | 1 | Master enable level |
| ien_o | output | 3 | Event enables {ack, wait, data-empty} |
| start_cmd_o | output | 1 | One-cycle START request |
| stop_cmd_o | output | 1 | One-cycle STOP request |
| wr_o | output | 1 | One-cycle byte write strobe |
| wdata_o | output | DATA_W | Byte to write |
| wait_rel_o | output | 1 | One-cycle wait release |
| clr_arb_o | output | 1 | One-cycle clear of the arbitration flag |
| clr_nack_o | output | 1 | One-cycle clear of the acknowledge flag |
| done_o | output | 1 | Sticky success flag |
| fault_o | output | 1 | Sticky failure flag |

## Verification
The lookup is tried with each of the eight single keys. It is also tried with codes that set two bits or a bit above the keys (0x003, 0x080, 0x100), which show that the fallback to entry 0 is taken only when nothing matches. Two codes with bits above bit 8 set (0xFE01, 0x200) show that the mask is applied before the compare, because they land on entries 1 and 0. A scripted master model injects lost arbitration after START, after the register byte and after the data byte, a missing acknowledge after the address, and both flags at once. Each injection leaves its own trace of commands, so the trace shows which recovery path ran and whether the dummy byte was sent. A repeated injection on every attempt shows the retry limit and that the fault flag holds.

// File: rtl/vcl_pkg.sv
package vcl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_BEGIN     = 4'd1,
    ST_ADDR      = 4'd2,
    ST_REG       = 4'd3,
    ST_DATA      = 4'd4,
    ST_FIN       = 4'd5,
    ST_DRAIN     = 4'd6,
    ST_DONE      = 4'd7,
    ST_AL_START  = 4'd8,
    ST_AL_XFER   = 4'd9,
    ST_NACK      = 4'd10,
    ST_ERR_STOP  = 4'd11,
    ST_ERR_DRAIN = 4'd12,
    ST_FAULT     = 4'd13
  } seq_state_t;

  // event enable vector layout
  localparam int IEN_W    = 3;
  localparam int IEN_ACK  = 2;
  localparam int IEN_WAIT = 1;
  localparam int IEN_TXE  = 0;

endpackage

// File: rtl/vcl_code_map.sv
module vcl_code_map #(
  parameter int              CODE_W   = 9,
  parameter int              ENTRIES  = 8,
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] BASE_VID = 8'h53
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] vid_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   idx;

  // entry 0 keys on zero, entry e>0 keys on a single set bit e-1
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_key
      localparam int SH = (e == 0) ? 0 : e - 1;
      localparam logic [CODE_W-1:0] KEY = (e == 0) ? '0 : (CODE_W'(1) << SH);
      assign match[e] = (code_i == KEY);
    end
  endgenerate

  // no hit leaves idx at entry 0
  always_comb begin
    idx = '0;
    for (int e = ENTRIES - 1; e > 0; e--) begin
      if (match[e]) idx = IDX_W'(e);
    end
  end

  assign vid_o = BASE_VID - DATA_W'(idx);

endmodule

// File: rtl/vcl_retry_guard.sv
module vcl_retry_guard #(
  parameter int MAX_RETRY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic bump_i,
  output logic spent_o
);
  localparam int CNT_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (bump_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q >= LIMIT);

endmodule

// File: rtl/vcl_gap_timer.sv
module vcl_gap_timer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic ready_o
);
  localparam int GW = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load_i)     cnt_q <= GW'(GAP_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == 0);

endmodule

// File: rtl/volt_code_seq.sv
module volt_code_seq
  import vcl_pkg::*;
#(
  parameter int                RAW_W     = 16,
  parameter int                CODE_W    = 9,
  parameter int                ENTRIES   = 8,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] BASE_VID  = 8'h53,
  parameter logic [DATA_W-1:0] ADDR_BYTE = 8'h60,
  parameter logic [DATA_W-1:0] REG_BYTE  = 8'h54,
  parameter int                MAX_RETRY = 1,
  parameter int                GAP_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RAW_W-1:0]  fuse_code_i,
  input  logic              txe_i,
  input  logic              wait_i,
  input  logic              arb_lost_i,
  input  logic              nack_i,
  input  logic              busy_i,
  output logic              mst_en_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic              start_cmd_o,
  output logic              stop_cmd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wait_rel_o,
  output logic              clr_arb_o,
  output logic              clr_nack_o,
  output logic              done_o,
  output logic              fault_o
);

  // ---------------- lookup ----------------
  logic [DATA_W-1:0] map_vid;

  generate
    if (RAW_W > CODE_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^fuse_code_i[RAW_W-1:CODE_W];
    end
  endgenerate

  vcl_code_map #(
    .CODE_W  (CODE_W),
    .ENTRIES (ENTRIES),
    .DATA_W  (DATA_W),
    .BASE_VID(BASE_VID)
  ) u_map (
    .code_i(fuse_code_i[CODE_W-1:0]),
    .vid_o (map_vid)
  );

  // ---------------- retry budget and settle gap ----------------
  logic bump, spent, gap_ready, gap_load;

  vcl_retry_guard #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk    (clk),
    .rst    (rst),
    .bump_i (bump),
    .spent_o(spent)
  );

  vcl_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .load_i (gap_load),
    .ready_o(gap_ready)
  );

  // ---------------- sequencer ----------------
  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] vid_q, vid_d;
  logic              en_q, en_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic              start_d, stop_d, wr_d, rel_d, clra_d, clrn_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              done_q, done_d, fault_q, fault_d;
  logic              in_xfer, err_seen;

  assign in_xfer  = (st_q == ST_ADDR) || (st_q == ST_REG) ||
                    (st_q == ST_DATA) || (st_q == ST_FIN);
  assign err_seen = arb_lost_i || nack_i;

  always_comb begin
    st_d    = st_q;
    vid_d   = vid_q;
    en_d    = en_q;
    ien_d   = ien_q;
    wdata_d = wdata_q;
    done_d  = done_q;
    fault_d = fault_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    wr_d    = 1'b0;
    rel_d   = 1'b0;
    clra_d  = 1'b0;
    clrn_d  = 1'b0;
    bump    = 1'b0;

    if (gap_ready && in_xfer && err_seen) begin
      if (spent) begin
        st_d    = ST_FAULT;
        fault_d = 1'b1;
        en_d    = 1'b0;
        ien_d   = '0;
      end else if (arb_lost_i) begin
        // arbitration has priority over a missing acknowledge
        st_d = (st_q == ST_ADDR) ? ST_AL_START : ST_AL_XFER;
      end else begin
        st_d = ST_NACK;
      end
    end else if (gap_ready) begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            vid_d = map_vid;
            st_d  = ST_BEGIN;
          end
        end
        ST_BEGIN: begin
          en_d    = 1'b1;
          ien_d   = '1;
          start_d = 1'b1;
          st_d    = ST_ADDR;
        end
        ST_ADDR: begin
          if (txe_i) begin
            wr_d           = 1'b1;
            wdata_d        = ADDR_BYTE;
            ien_d[IEN_TXE] = 1'b0;
            st_d           = ST_REG;
          end
        end
        ST_REG: begin
          if (wait_i) begin
            wr_d    = 1'b1;
            wdata_d = REG_BYTE;
            rel_d   = 1'b1;
            st_d    = ST_DATA;
          end
        end
        ST_DATA: begin
          if (wait_i) begin
            wr_d    = 1'b1;
            wdata_d = vid_q;
            rel_d   = 1'b1;
            st_d    = ST_FIN;
          end
        end
        ST_FIN: begin
          if (wait_i) begin
            stop_d = 1'b1;
            rel_d  = 1'b1;
            st_d   = ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!busy_i) begin
            en_d   = 1'b0;
            ien_d  = '0;
            done_d = 1'b1;
            st_d   = ST_DONE;
          end
        end
        ST_AL_START: begin
          clra_d  = 1'b1;
          wr_d    = 1'b1;
          wdata_d = BASE_VID;  // dummy byte to clock the bus
          st_d    = ST_ERR_STOP;
        end
        ST_AL_XFER: begin
          clra_d = 1'b1;
          st_d   = ST_ERR_STOP;
        end
        ST_NACK: begin
          stop_d          = 1'b1;
          clrn_d          = 1'b1;
          ien_d[IEN_WAIT] = 1'b0;
          ien_d[IEN_TXE]  = 1'b0;
          st_d            = ST_ERR_DRAIN;
        end
        ST_ERR_STOP: begin
          if (wait_i) begin
            stop_d = 1'b1;
            rel_d  = 1'b1;
            st_d   = ST_ERR_DRAIN;
          end
        end
        ST_ERR_DRAIN: begin
          if (!busy_i) begin
            en_d  = 1'b0;
            ien_d = '0;
            bump  = 1'b1;
            st_d  = ST_BEGIN;
          end
        end
        ST_DONE, ST_FAULT: ;
        default: begin
          st_d    = ST_FAULT;
          fault_d = 1'b1;
          done_d  = 1'b0;
          en_d    = 1'b0;
          ien_d   = '0;
        end
      endcase
    end
  end

  assign gap_load = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      vid_q       <= '0;
      en_q        <= 1'b0;
      ien_q       <= '0;
      wdata_q     <= '0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      start_cmd_o <= 1'b0;
      stop_cmd_o  <= 1'b0;
      wr_o        <= 1'b0;
      wait_rel_o  <= 1'b0;
      clr_arb_o   <= 1'b0;
      clr_nack_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      vid_q       <= vid_d;
      en_q        <= en_d;
      ien_q       <= ien_d;
      wdata_q     <= wdata_d;
      done_q      <= done_d;
      fault_q     <= fault_d;
      start_cmd_o <= start_d;
      stop_cmd_o  <= stop_d;
      wr_o        <= wr_d;
      wait_rel_o  <= rel_d;
      clr_arb_o   <= clra_d;
      clr_nack_o  <= clrn_d;
    end
  end

  assign mst_en_o = en_q;
  assign ien_o    = ien_q;
  assign wdata_o  = wdata_q;
  assign done_o   = done_q;
  assign fault_o  = fault_q;

endmodule

// File: rtl/vcl_seq_checker.sv
module vcl_seq_checker #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] ADDR_BYTE = 8'h60
) (
  input logic              clk,
  input logic              rst,
  input logic              txe_i,
  input logic              wait_i,
  input logic              busy_i,
  input logic              mst_en_o,
  input logic [2:0]        ien_o,
  input logic              start_cmd_o,
  input logic              stop_cmd_o,
  input logic              wr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              wait_rel_o,
  input logic              clr_nack_o,
  input logic              done_o,
  input logic              fault_o
);

  p_done_fault_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fault_o));

  p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);

  p_quiet_after_end_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o || fault_o) |-> !(start_cmd_o || stop_cmd_o || wr_o || mst_en_o));

  p_addr_after_txe_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_o && wdata_o == ADDR_BYTE) |-> $past(txe_i));

  p_release_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
    wait_rel_o |-> $past(wait_i));

  p_done_after_idle_bus_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(!busy_i));

  p_nack_enables_r7: assert property (@(posedge clk) disable iff (rst)
    clr_nack_o |-> (ien_o == 3'b100 && stop_cmd_o));

endmodule

bind volt_code_seq vcl_seq_checker #(
  .DATA_W   (DATA_W),
  .ADDR_BYTE(ADDR_BYTE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .txe_i      (txe_i),
  .wait_i     (wait_i),
  .busy_i     (busy_i),
  .mst_en_o   (mst_en_o),
  .ien_o      (ien_o),
  .start_cmd_o(start_cmd_o),
  .stop_cmd_o (stop_cmd_o),
  .wr_o       (wr_o),
  .wdata_o    (wdata_o),
  .wait_rel_o (wait_rel_o),
  .clr_nack_o (clr_nack_o),
  .done_o     (done_o),
  .fault_o    (fault_o)
);

// File: tb/sim_volt_code_seq.sv
`timescale 1ns/1ps
module sim_volt_code_seq;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, start;
  logic [15:0] code;
  logic        txe, wt, arb, nack, busy;
  logic        en, st_c, sp_c, wr, rel, ca, cn, done, fault;
  logic [2:0]  ien;
  logic [7:0]  wdata;

  volt_code_seq u0 (
    .clk(clk), .rst(rst), .start_i(start), .fuse_code_i(code),
    .txe_i(txe), .wait_i(wt), .arb_lost_i(arb), .nack_i(nack), .busy_i(busy),
    .mst_en_o(en), .ien_o(ien), .start_cmd_o(st_c), .stop_cmd_o(sp_c),
    .wr_o(wr), .wdata_o(wdata), .wait_rel_o(rel), .clr_arb_o(ca),
    .clr_nack_o(cn), .done_o(done), .fault_o(fault)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // event trace tags
  localparam int T_START = 1, T_BYTE = 2, T_STOP = 3, T_CARB = 4, T_CNACK = 5;
  localparam int K_TXE = 1, K_BYTE = 2, K_WAIT = 3, K_STOP = 4;

  logic [11:0] ev_log [32];
  int          ev_n;
  logic [2:0]  ien_nack;
  logic [11:0] exp_ev [32];
  int          exp_n;

  // injection script
  int inj_pt;   // -1 none, 0 after START, k after k-th byte of an attempt
  int inj_kind; // bit0 arbitration, bit1 missing acknowledge
  bit inj_all;
  bit inj_used;
  int attempt, nbytes, pend_cnt, pend_kind;

  function automatic bit fire(int pt);
    return (inj_pt == pt) && !inj_used && (inj_all || attempt == 1);
  endfunction

  // master model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst) begin
      txe = 0; wt = 0; arb = 0; nack = 0; busy = 0;
      pend_cnt = 0; pend_kind = 0; attempt = 0; nbytes = 0; inj_used = 0;
      ev_n = 0; ien_nack = 3'b111;
    end else begin
      if (!en) begin txe = 0; wt = 0; arb = 0; nack = 0; end
      if (rel) wt = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          case (pend_kind)
            K_TXE:  if (fire(0)) begin
                      inj_used = 1; arb = inj_kind[0]; nack = inj_kind[1];
                    end else txe = 1;
            K_BYTE: if (fire(nbytes)) begin
                      inj_used = 1; arb = inj_kind[0]; nack = inj_kind[1];
                    end else wt = 1;
            K_WAIT: wt = 1;
            K_STOP: begin busy = 0; wt = 0; end
            default: ;
          endcase
        end
      end
      if (ca) begin arb = 0; log_ev(T_CARB, 8'h00); pend_cnt = 3; pend_kind = K_WAIT; end
      if (cn) begin nack = 0; log_ev(T_CNACK, 8'h00); ien_nack = ien; end
      if (wr) begin log_ev(T_BYTE, wdata); txe = 0; nbytes++; pend_cnt = 3; pend_kind = K_BYTE; end
      if (sp_c) begin log_ev(T_STOP, 8'h00); pend_cnt = 4; pend_kind = K_STOP; end
      if (st_c) begin
        log_ev(T_START, 8'h00); busy = 1; attempt++; nbytes = 0; inj_used = 0;
        pend_cnt = 3; pend_kind = K_TXE;
      end
    end
  end

  task automatic log_ev(input int tag, input logic [7:0] b);
    if (ev_n < 32) ev_log[ev_n] = {tag[3:0], b};
    ev_n++;
  endtask

  task automatic ex(input int tag, input logic [7:0] b);
    exp_ev[exp_n] = {tag[3:0], b};
    exp_n++;
  endtask

  task automatic ex_clean(input logic [7:0] v);
    ex(T_START, 8'h00); ex(T_BYTE, 8'h60); ex(T_BYTE, 8'h54); ex(T_BYTE, v); ex(T_STOP, 8'h00);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic chk_log(input string req);
    chk(ev_n == exp_n, req, "trace length", ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n && i < 32; i++)
      chk(ev_log[i] == exp_ev[i], req, $sformatf("trace entry %0d", i),
          int'(ev_log[i]), int'(exp_ev[i]));
  endtask

  task automatic run_seq(input logic [15:0] c, input int pt, input int kind, input bit all);
    rst = 1; start = 0; code = c;
    inj_pt = pt; inj_kind = kind; inj_all = all; exp_n = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 3000 && !(done || fault); n++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // {fallback entry expected, code, expected voltage ID}
  localparam logic [24:0] VEC [13] = '{
    {1'b0, 16'h0000, 8'h53}, {1'b0, 16'h0001, 8'h52}, {1'b0, 16'h0002, 8'h51},
    {1'b0, 16'h0004, 8'h50}, {1'b0, 16'h0008, 8'h4F}, {1'b0, 16'h0010, 8'h4E},
    {1'b0, 16'h0020, 8'h4D}, {1'b0, 16'h0040, 8'h4C}, {1'b1, 16'h0003, 8'h53},
    {1'b1, 16'h0080, 8'h53}, {1'b1, 16'h0100, 8'h53}, {1'b0, 16'hFE01, 8'h52},
    {1'b0, 16'h0200, 8'h53}
  };

  initial begin
    rst = 1; start = 0; code = '0; inj_pt = -1; inj_kind = 0; inj_all = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({en, ien, st_c, sp_c, wr, wdata, rel, ca, cn, done, fault} == '0,
        "R10", "reset outputs", int'({en, ien, wr, done, fault}), 0);

    // table walk: R1 keys and mask, R2 fallback, R3 order, R4 completion
    foreach (VEC[k]) begin
      run_seq(VEC[k][23:8], -1, 0, 0);
      ex_clean(VEC[k][7:0]);
      chk_log("R3");
      chk(ev_n > 3 && ev_log[3][7:0] == VEC[k][7:0], VEC[k][24] ? "R2" : "R1",
          $sformatf("voltage ID for code 0x%0h", VEC[k][23:8]),
          int'(ev_log[3][7:0]), int'(VEC[k][7:0]));
      chk(done == 1 && en == 0 && ien == 0, "R4", "done with master off",
          int'({done, en, ien}), 32'h10);
      chk(fault == 0, "R10", "no fault on clean run", int'(fault), 0);
    end

    // R4: a second start after done issues nothing
    start = 1; @(negedge clk); start = 0;
    repeat (100) @(negedge clk);
    chk(ev_n == 5 && done == 1, "R4", "start after done ignored", ev_n, 5);

    // R5: arbitration lost after START, dummy byte is the entry-0 ID
    run_seq(16'h0040, 0, 1, 0);
    ex(T_START, 0); ex(T_CARB, 0); ex(T_BYTE, 8'h53); ex(T_STOP, 0); ex_clean(8'h4C);
    chk_log("R5");
    chk(done == 1 && fault == 0, "R5", "done after retry", int'({done, fault}), 2);

    // R6: arbitration lost after the register byte
    run_seq(16'h0008, 2, 1, 0);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_BYTE, 8'h54); ex(T_CARB, 0); ex(T_STOP, 0);
    ex_clean(8'h4F);
    chk_log("R6");

    // R6: arbitration lost after the data byte
    run_seq(16'h0008, 3, 1, 0);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_BYTE, 8'h54); ex(T_BYTE, 8'h4F);
    ex(T_CARB, 0); ex(T_STOP, 0); ex_clean(8'h4F);
    chk_log("R6");
    chk(done == 1, "R6", "done after retry", int'(done), 1);

    // R7: missing acknowledge on the address byte
    run_seq(16'h0002, 1, 2, 0);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_CNACK, 0); ex(T_STOP, 0); ex_clean(8'h51);
    chk_log("R7");
    chk(ien_nack == 3'b100, "R7", "event enables at acknowledge clear",
        int'(ien_nack), 4);
    chk(done == 1 && fault == 0, "R7", "done after retry", int'({done, fault}), 2);

    // R8: both flags at once, arbitration path wins
    run_seq(16'h0010, 1, 3, 0);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_CARB, 0); ex(T_STOP, 0); ex_clean(8'h4E);
    chk_log("R8");

    // R9: error on every attempt, fault after one retry
    run_seq(16'h0001, 2, 1, 1);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_BYTE, 8'h54); ex(T_CARB, 0); ex(T_STOP, 0);
    ex(T_START, 0); ex(T_BYTE, 8'h60); ex(T_BYTE, 8'h54);
    chk_log("R9");
    chk(fault == 1 && done == 0 && en == 0, "R9", "fault raised, master off",
        int'({fault, done, en}), 4);
    start = 1; @(negedge clk); start = 0;
    repeat (100) @(negedge clk);
    chk(fault == 1 && ev_n == 8, "R9", "fault sticky and start ignored", ev_n, 8);
    chk(!(done && fault), "R10", "done and fault exclusive", int'({done, fault}), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule